// File: doc/BRIEF.md
# Byte-Level I2C Master Controller

This block is an I2C bus master driven through a small register port. Software writes one command word per bus byte: the word can open the transfer with a START (or a repeated START), carry the byte to shift out, choose whether the master acknowledges a received byte, or close the transfer with a STOP. After each byte software reads a status word holding a busy flag, the acknowledge level the slave returned, an arbitration-lost flag and the last received byte.

The bus pins are open-drain: `scl_oe` and `sda_oe` pull their line low when 1, and `scl_i` and `sda_i` return the wired bus level. Bit timing comes from a clock register that gives the SCL period and the length of its low phase in input-clock cycles. A bus-control register holds the engine in reset, or keeps it idle with its outputs released while the timing is changed. When the released SCL line is seen low during the high phase, the master waits.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the status word (offset 0x04) reads 0, the clock word (0x0C) reads {16'd125, 16'd250}, the bus-control word (0x10) reads 0, and both `scl_oe` and `sda_oe` are 0.
- R2: The clock word holds the SCL low-phase length in bits 31:16 and the full SCL period in bits 15:0. Each bit slot drives SCL low for the low-phase count and then releases it for the rest of the period, so a byte command makes 9 SCL high pulses of (period - low phase) cycles each.
- R3: A START is SDA falling while SCL is high and a STOP is SDA rising while SCL is high. SDA makes no other change while SCL is high, and the master changes SDA only partway through the SCL low phase.
- R4: The command word at offset 0x00 uses bit 10 = START first, bit 9 = STOP, bit 8 = NACK and bits 7:0 = byte. Bytes go out MSB first. Status bit 12 (busy) is 1 from the cycle after the command write until the acknowledge slot of the byte ends.
- R5: After a byte the master transmits (the address byte included), status bit 11 holds the sampled acknowledge level: 0 = acknowledged, 1 = not acknowledged.
- R6: Bit 0 of the byte sent with START selects the direction (1 = read). In read direction, later byte commands release SDA and shift in 8 bits, which appear in status bits 7:0. The master then drives the acknowledge low when command bit 8 is 0 and leaves it released when bit 8 is 1.
- R7: If the master releases SDA for a 1 but samples it low while SCL is high, it sets status bit 9, releases both lines and ends the command.
- R8: A command with bit 9 set performs only a STOP and ignores bits 10 and 7:0. It is ignored completely while status bit 9 is set. The next START command clears bit 9.
- R9: The bus-control word uses bit 0 = run and bit 1 = output enable. Only the value 2'b11 lets commands execute. Any other value keeps both lines released and commands have no effect.
- R10: A command written while busy is 1 is ignored.
- R11: While the released SCL line reads low during a high phase, bit timing pauses, and the byte then completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Register read data for reg_addr |
| scl_i | input | 1 | Sampled SCL bus level |
| sda_i | input | 1 | Sampled SDA bus level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The hardest situation to bring about from the ports is arbitration loss, because the bus model must pull SDA low exactly while the master has it released during a data bit. The bench reaches it with a jamming driver on the wired SDA line. The driver is turned on in the same cycle as a command of all ones, so the first sampled bit fails. Releasing the jam with SCL high also gives the bus model a STOP, and the bench then confirms that a STOP command is refused and that the next START recovers. A second bench driver holds SCL low in the middle of a byte to exercise the wait.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int AW = 8,
  parameter logic [15:0] DEF_FULL = 16'd250,
  parameter logic [15:0] DEF_HALF = 16'd125
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  input  logic          reg_we,
  output logic [31:0]   reg_rdata,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe
);
  localparam logic [AW-1:0] A_CMD = AW'(8'h00);
  localparam logic [AW-1:0] A_STS = AW'(8'h04);
  localparam logic [AW-1:0] A_CLK = AW'(8'h0C);
  localparam logic [AW-1:0] A_CTL = AW'(8'h10);

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_ACK, S_STOP} st_t;
  st_t st;

  logic [31:0] clkr;
  logic [1:0]  ctl;
  logic [15:0] cnt;
  logic [2:0]  bitn;
  logic [7:0]  shreg, rxd;
  logic        rd_mode, is_rd, nack_q, sda_rel, scl_hold;
  logic        lrb, lab, busy;

  wire [15:0] full  = clkr[15:0];
  wire [15:0] half  = clkr[31:16];
  wire [15:0] qpt   = half >> 1;
  wire [15:0] mhi   = half + ((full - half) >> 1);
  wire        run   = (ctl == 2'b11);
  wire        scl_hi = (cnt >= half);
  wire        last  = (cnt == full - 16'd1);
  wire        adv   = !(scl_hi && !scl_i);
  wire        acc   = reg_we && (reg_addr == A_CMD) && run && !busy;

  assign scl_oe = run && ((st == S_IDLE) ? scl_hold : !scl_hi);
  assign sda_oe = run && !sda_rel;

  always_comb begin
    case (reg_addr)
      A_STS:   reg_rdata = {19'd0, busy, lrb, 1'b0, lab, 1'b0, rxd};
      A_CLK:   reg_rdata = clkr;
      A_CTL:   reg_rdata = {30'd0, ctl};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; clkr <= {DEF_HALF, DEF_FULL}; ctl <= 2'b00;
      cnt <= '0; bitn <= '0; shreg <= '0; rxd <= '0;
      rd_mode <= 1'b0; is_rd <= 1'b0; nack_q <= 1'b0;
      sda_rel <= 1'b1; scl_hold <= 1'b0; lrb <= 1'b0; lab <= 1'b0; busy <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_CLK) clkr <= reg_wdata;
      if (reg_we && reg_addr == A_CTL) ctl <= reg_wdata[1:0];
      if (!run) begin
        st <= S_IDLE; busy <= 1'b0; scl_hold <= 1'b0; sda_rel <= 1'b1; cnt <= '0;
        if (!ctl[0]) begin lab <= 1'b0; lrb <= 1'b0; rxd <= '0; end
      end else if (acc) begin
        if (!(reg_wdata[9] && lab)) begin
          busy <= 1'b1; cnt <= '0; lab <= 1'b0; bitn <= 3'd7;
          nack_q <= reg_wdata[8]; shreg <= reg_wdata[7:0];
          if (reg_wdata[9]) st <= S_STOP;
          else if (reg_wdata[10]) begin
            st <= S_START; rd_mode <= reg_wdata[0]; is_rd <= 1'b0; lrb <= 1'b0;
          end else begin
            st <= S_BIT; is_rd <= rd_mode; lrb <= 1'b0;
          end
        end
      end else if (st != S_IDLE && adv) begin
        cnt <= last ? 16'd0 : cnt + 16'd1;
        case (st)
          S_START: begin
            if (cnt == qpt) sda_rel <= 1'b1;
            if (cnt == mhi) sda_rel <= 1'b0;
            if (last) begin st <= S_BIT; bitn <= 3'd7; end
          end
          S_BIT: begin
            if (cnt == qpt) sda_rel <= is_rd | shreg[7];
            if (last) begin
              if (!is_rd && sda_rel && !sda_i) begin
                lab <= 1'b1; st <= S_IDLE; busy <= 1'b0; scl_hold <= 1'b0;
              end else begin
                shreg <= {shreg[6:0], sda_i};
                bitn  <= bitn - 3'd1;
                if (bitn == 3'd0) st <= S_ACK;
              end
            end
          end
          S_ACK: begin
            if (cnt == qpt) sda_rel <= is_rd ? nack_q : 1'b1;
            if (last) begin
              if (is_rd) rxd <= shreg;
              else       lrb <= sda_i;
              st <= S_IDLE; busy <= 1'b0; scl_hold <= 1'b1;
            end
          end
          S_STOP: begin
            if (cnt == qpt) sda_rel <= 1'b0;
            if (cnt == mhi) sda_rel <= 1'b1;
            if (last) begin st <= S_IDLE; busy <= 1'b0; scl_hold <= 1'b0; end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_sda_in_low_phase_R3: assert property (@(posedge clk) disable iff (!rst_n || !run)
    (st == S_BIT || st == S_ACK) && ($past(st) == S_BIT || $past(st) == S_ACK) &&
    (sda_oe != $past(sda_oe)) |-> scl_oe && $past(scl_oe));

  assert_start_edge_R3: assert property (@(posedge clk) disable iff (!rst_n || !run)
    st == S_START && $past(st) == S_START && $rose(sda_oe) |-> !scl_oe);

  assert_stop_edge_R3: assert property (@(posedge clk) disable iff (!rst_n || !run)
    st == S_STOP && $past(st) == S_STOP && $fell(sda_oe) |-> !scl_oe);

  assert_lost_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lab) |-> !scl_oe && !sda_oe);

  assert_busy_from_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && reg_addr == A_CMD));
endmodule

// File: tb/i2c_byte_master_bench.sv
`timescale 1ns/1ps
module i2c_byte_master_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic scl_oe, sda_oe;
  logic jam = 1'b0, stretch = 1'b0, meas_clr = 1'b0, s_drv;
  wire scl_w = !(scl_oe || stretch);
  wire sda_w = !(sda_oe || s_drv || jam);

  always #2.5 clk = ~clk;

  i2c_byte_master u_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .scl_i(scl_w), .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe));

  localparam logic [6:0] SLV = 7'h3A;
  localparam int FULL = 10, HALF = 4;

  function automatic logic [7:0] txb(input int i);
    return 8'hA5 ^ 8'(i * 37);
  endfunction

  // slave model on the wired bus
  typedef enum logic [2:0] {SI, SADDR, SWR, SACKA, SACKW, SRD, SMACK} sst_t;
  sst_t sst;
  logic ps = 1'b1, pd = 1'b1, sel_rd, mack_q;
  logic [3:0] bc;
  logic [7:0] sh;
  logic [7:0] slog [64];
  logic mlog [64];
  int scount = 0, ti = 0;
  always @(posedge clk) begin
    ps <= scl_w; pd <= sda_w;
    if (!rst_n) begin sst <= SI; s_drv <= 1'b0; bc <= '0; end
    else if (ps && scl_w && pd && !sda_w) begin sst <= SADDR; bc <= '0; s_drv <= 1'b0; end
    else if (ps && scl_w && !pd && sda_w) begin sst <= SI; s_drv <= 1'b0; end
    else if (!ps && scl_w) begin
      if (sst == SADDR || sst == SWR) begin sh <= {sh[6:0], sda_w}; bc <= bc + 4'd1; end
      else if (sst == SRD) bc <= bc + 4'd1;
      else if (sst == SMACK) begin mack_q <= !sda_w; mlog[ti[5:0]] <= !sda_w; ti <= ti + 1; end
    end else if (ps && !scl_w) begin
      case (sst)
        SADDR: if (bc == 4'd8) begin
          if (sh[7:1] == SLV) begin s_drv <= 1'b1; sel_rd <= sh[0]; sst <= SACKA; end
          else sst <= SI;
        end
        SWR: if (bc == 4'd8) begin
          slog[scount[5:0]] <= sh; scount <= scount + 1; s_drv <= 1'b1; sst <= SACKW;
        end
        SACKA: begin
          bc <= '0;
          if (sel_rd) begin sh <= txb(ti); s_drv <= !txb(ti)[7]; sst <= SRD; end
          else begin s_drv <= 1'b0; sst <= SWR; end
        end
        SACKW: begin s_drv <= 1'b0; bc <= '0; sst <= SWR; end
        SRD: if (bc == 4'd8) begin s_drv <= 1'b0; sst <= SMACK; end
             else s_drv <= !sh[3'(7 - bc)];
        SMACK: if (mack_q) begin sh <= txb(ti); s_drv <= !txb(ti)[7]; bc <= '0; sst <= SRD; end
               else begin s_drv <= 1'b0; sst <= SI; end
        default: ;
      endcase
    end
  end

  // bus monitor
  int hi_chg, hw_min, hw_max, hp_n, run_len;
  always @(posedge clk) begin
    if (meas_clr) begin hi_chg <= 0; hw_min <= 9999; hw_max <= 0; hp_n <= 0; run_len <= 0; end
    else begin
      if (ps && scl_w && pd != sda_w) hi_chg <= hi_chg + 1;
      if (scl_w) run_len <= run_len + 1;
      else begin
        if (ps) begin
          hp_n <= hp_n + 1;
          if (run_len < hw_min) hw_min <= run_len;
          if (run_len > hw_max) hw_max <= run_len;
        end
        run_len <= 0;
      end
    end
  end

  int nchk = 0, nerr = 0;
  bit done = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin nerr++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask
  task automatic wait_idle;
    logic [31:0] s;
    int n = 0;
    do begin rd(8'h04, s); n++; end while (s[12] && n < 20000);
    repeat (3) @(negedge clk);
  endtask
  task automatic clr;
    @(negedge clk); meas_clr = 1'b1; @(negedge clk); meas_clr = 1'b0;
  endtask

  task automatic do_write(input int n, input logic [7:0] b0);
    logic [31:0] s;
    int base = scount;
    logic [7:0] d [4];
    clr();
    wr(8'h00, 32'h500 | {24'd0, SLV, 1'b0}); wait_idle(); rd(8'h04, s);
    chk(s[11] == 1'b0, "R5 address ack", {31'd0, s[11]}, 0);
    for (int i = 0; i < n; i++) begin
      d[i] = (i == 0) ? b0 : 8'($urandom);
      wr(8'h00, 32'h100 | {24'd0, d[i]}); wait_idle(); rd(8'h04, s);
      chk(s[11] == 1'b0, "R5 data ack", {31'd0, s[11]}, 0);
    end
    wr(8'h00, 32'h3FF); wait_idle();
    for (int i = 0; i < n; i++)
      chk(slog[(base + i) % 64] == d[i], "R4 byte at slave", {24'd0, slog[(base + i) % 64]}, {24'd0, d[i]});
    chk(scount == base + n, "R4 byte count", scount, base + n);
    chk(hi_chg == 2, "R3 SDA edges with SCL high", hi_chg, 2);
    chk(!scl_oe && !sda_oe, "R3 lines released after stop", {scl_oe, sda_oe}, 0);
  endtask

  task automatic do_read(input int n);
    logic [31:0] s;
    int base = ti;
    wr(8'h00, 32'h500 | {24'd0, SLV, 1'b1}); wait_idle(); rd(8'h04, s);
    chk(s[11] == 1'b0, "R5 read address ack", {31'd0, s[11]}, 0);
    for (int i = 0; i < n; i++) begin
      wr(8'h00, (i == n - 1) ? 32'h100 : 32'h000); wait_idle(); rd(8'h04, s);
      chk(s[7:0] == txb(base + i), "R6 read data", {24'd0, s[7:0]}, {24'd0, txb(base + i)});
      chk(mlog[(base + i) % 64] == (i != n - 1), "R6 master ack level",
          {31'd0, mlog[(base + i) % 64]}, {31'd0, i != n - 1});
    end
    wr(8'h00, 32'h300); wait_idle();
    chk(ti == base + n, "R6 byte count", ti, base + n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    int base;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk); rst_n = 1'b1;
    rd(8'h04, s); chk(s == 0, "R1 status after reset", s, 0);
    rd(8'h0C, s); chk(s == {16'd125, 16'd250}, "R1 clock after reset", s, {16'd125, 16'd250});
    rd(8'h10, s); chk(s == 0, "R1 control after reset", s, 0);
    chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);

    // not running: commands have no effect (R9)
    wr(8'h00, 32'h574); rd(8'h04, s);
    chk(s[12] == 1'b0 && !scl_oe && !sda_oe, "R9 command ignored when stopped", s, 0);
    wr(8'h10, 32'h1);
    wr(8'h0C, {16'(HALF), 16'(FULL)});
    rd(8'h0C, s); chk(s == {16'(HALF), 16'(FULL)}, "R2 clock readback", s, {16'(HALF), 16'(FULL)});
    wr(8'h00, 32'h574); rd(8'h04, s);
    chk(s[12] == 1'b0 && !scl_oe && !sda_oe, "R9 ignored with outputs off", s, 0);
    wr(8'h10, 32'h3); rd(8'h10, s); chk(s == 3, "R9 control readback", s, 3);

    do_write(2, 8'hC3);

    // bit timing on a mid-transfer byte (R2)
    wr(8'h00, 32'h500 | {24'd0, SLV, 1'b0}); wait_idle();
    clr();
    wr(8'h00, 32'h15A); wait_idle();
    chk(hp_n == 9, "R2 high pulses per byte", hp_n, 9);
    chk(hw_min == FULL - HALF && hw_max == FULL - HALF, "R2 high width", {hw_min[15:0], hw_max[15:0]}, FULL - HALF);

    // command while busy (R10)
    base = scount;
    wr(8'h00, 32'h1A7); wr(8'h00, 32'h111); wait_idle();
    chk(scount == base + 1 && slog[base % 64] == 8'hA7, "R10 busy command ignored", scount, base + 1);

    // SCL held low by the bus (R11)
    base = scount;
    wr(8'h00, 32'h13C); stretch = 1'b1;
    repeat (150) @(negedge clk);
    rd(8'h04, s); chk(s[12] == 1'b1, "R11 waits while SCL held", {31'd0, s[12]}, 1);
    stretch = 1'b0; wait_idle();
    chk(scount == base + 1 && slog[base % 64] == 8'h3C, "R11 byte after wait", {24'd0, slog[base % 64]}, 32'h3C);
    wr(8'h00, 32'h300); wait_idle();

    do_read(3);

    // missing acknowledge (R5)
    wr(8'h00, 32'h500 | {24'd0, 7'h12, 1'b0}); wait_idle(); rd(8'h04, s);
    chk(s[11] == 1'b1, "R5 no ack on wrong address", {31'd0, s[11]}, 1);
    wr(8'h00, 32'h300); wait_idle();

    // arbitration loss (R7, R8)
    base = scount;
    wr(8'h00, 32'h500 | {24'd0, SLV, 1'b0}); wait_idle();
    @(negedge clk); reg_addr = 8'h00; reg_wdata = 32'h1FF; reg_we = 1'b1; jam = 1'b1;
    @(negedge clk); reg_we = 1'b0;
    wait_idle(); rd(8'h04, s);
    chk(s[9] == 1'b1, "R7 arbitration flag", {31'd0, s[9]}, 1);
    chk(!scl_oe && !sda_oe, "R7 lines released", {scl_oe, sda_oe}, 0);
    jam = 1'b0; repeat (3) @(negedge clk);
    wr(8'h00, 32'h300); rd(8'h04, s);
    chk(s[12] == 1'b0 && s[9] == 1'b1 && !scl_oe && !sda_oe, "R8 stop refused after loss", s, 32'h200);
    chk(scount == base, "R7 no byte delivered", scount, base);
    wr(8'h00, 32'h500 | {24'd0, SLV, 1'b0}); wait_idle(); rd(8'h04, s);
    chk(s[9] == 1'b0, "R8 start clears flag", {31'd0, s[9]}, 0);
    wr(8'h00, 32'h2A5); wait_idle();
    chk(scount == base && !scl_oe && !sda_oe, "R8 stop ignores data", scount, base);

    for (int k = 0; k < 6; k++) begin
      if ($urandom % 2) do_write(1 + int'($urandom % 4), 8'($urandom));
      else do_read(1 + int'($urandom % 4));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule